// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit register file and a word-wide data memory that numbers its bytes big-endian. Byte offset 0 inside a word is the most significant byte. A request carries a store or load flag, an access size, a signedness flag, the two low address bits, the register value to store and the word already read from memory. The block registers its answer and presents it one clock later.

For a store, the block places the rightmost byte or halfword of the register value on the memory lanes and raises the write enables of only the addressed bytes, so the rest of the word is kept. For a load, it extracts the addressed byte or halfword from the memory word, right-justifies it and extends it with the sign or with zeros. A whole-word access passes all 32 bits through. An access that breaks the size alignment raises a misalign flag and writes nothing. Address generation, the memory array and exception handling are outside the block.

Top module: `memAligner`

## Requirements
- R1: While `rst` is high at a clock edge, `rspValid`, `wrEnable` and `misalign` are 0 after that edge, whatever the request inputs are.
- R2: A byte store (`reqSize` = 2'b00, `reqIsStore` = 1) at offset k drives `wrData` with `storeData[7:0]` replicated on all four lanes and sets only `wrEnable` bit 3-k. Offset 0 sets bit 3, which covers `wrData[31:24]`.
- R3: A halfword store (`reqSize` = 2'b01) at offset 0 sets `wrEnable` = 4'b1100, and at offset 2 sets 4'b0011. `wrData` carries `storeData[15:0]` in both bits 31:16 and bits 15:0.
- R4: A word store (`reqSize` = 2'b10) at offset 0 sets `wrEnable` = 4'b1111 with `wrData` equal to `storeData`.
- R5: A halfword access with address bit 0 set, a word access with a nonzero offset, or the reserved size code 2'b11 sets `misalign` = 1, `wrEnable` = 0 and `loadResult` = 0.
- R6: A load (`reqIsStore` = 0) never asserts any `wrEnable` bit.
- R7: A byte load at offset k returns memory bits (31-8k) down to (24-8k) in `loadResult[7:0]`. Bits 31:8 copy bit 7 when `reqUnsigned` = 0 and are zero when `reqUnsigned` = 1.
- R8: A halfword load returns memory bits 31:16 for offset 0 and bits 15:0 for offset 2 in `loadResult[15:0]`, extended by the same `reqUnsigned` rule.
- R9: A word load at offset 0 returns the whole memory word unchanged.
- R10: All outputs change one clock after a request is accepted. `rspValid` is high for exactly the cycles that follow a cycle with `reqValid` high. After a cycle with no request, `rspValid`, `wrEnable` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is present this cycle |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| reqUnsigned | input | 1 | 1 = zero-extend a load, 0 = sign-extend |
| reqAddrLow | input | 2 | Byte offset within the word |
| storeData | input | 32 | Register value to store |
| memReadWord | input | 32 | Word read from memory for a load |
| rspValid | output | 1 | Result of the previous cycle's request is present |
| wrData | output | 32 | Lane-aligned store data |
| wrEnable | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| loadResult | output | 32 | Extended load value |
| misalign | output | 1 | The previous request broke alignment |

## Verification
Misalignment detection and write-enable generation resolve in the same cycle. A misaligned halfword or word store must raise the flag and also suppress every lane it would otherwise have enabled. The bench provokes this with halfword stores at offsets 1 and 3, word stores at nonzero offsets and the reserved size code. It also mixes such requests into a random stream placed back to back with legal stores. Each cycle it compares the flag and the full enable vector against a byte-level model. A correct result needs the flag set and the enables all zero in the same response.

// File: rtl/memAlignPkg.sv
package memAlignPkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic     capture;
    logic     doWrite;
    logic     signExt;
    logic     misalign;
    accSize_e size;
  } alignStrobe_t;

endpackage

// File: rtl/memAlignCtrl.sv
module memAlignCtrl
  import memAlignPkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic             reqValid,
  input  logic             reqIsStore,
  input  logic [1:0]       reqSize,
  input  logic             reqUnsigned,
  input  logic [OFF_W-1:0] addrLow,
  output alignStrobe_t     strobe,
  output logic [LANES-1:0] laneMask
);

  accSize_e sizeCode;
  int       spanLanes;
  int       offset;
  logic     badAlign;
  logic     writeOk;

  always_comb begin
    sizeCode = accSize_e'(reqSize);
    offset   = int'(addrLow);
    case (sizeCode)
      SZ_BYTE: begin spanLanes = 1;     badAlign = 1'b0;       end
      SZ_HALF: begin spanLanes = 2;     badAlign = addrLow[0]; end
      SZ_WORD: begin spanLanes = LANES; badAlign = |addrLow;   end
      default: begin spanLanes = 0;     badAlign = 1'b1;       end
    endcase
    writeOk = reqValid & reqIsStore & ~badAlign;
  end

  always_comb begin
    strobe.capture  = reqValid;
    strobe.doWrite  = writeOk;
    strobe.signExt  = ~reqUnsigned;
    strobe.misalign = badAlign;
    strobe.size     = sizeCode;
  end

  // lane i holds byte offset LANES-1-i (big-endian numbering)
  for (genvar g = 0; g < LANES; g++) begin : gMask
    localparam int LANE_OFF = LANES - 1 - g;
    assign laneMask[g] = writeOk && (LANE_OFF >= offset) && (LANE_OFF < offset + spanLanes);
  end

endmodule

// File: rtl/memAlignData.sv
module memAlignData
  import memAlignPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  alignStrobe_t      strobe,
  input  logic [LANES-1:0]  laneMask,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memReadWord,
  output logic              rspValid,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  wrEnable,
  output logic [DATA_W-1:0] loadResult,
  output logic              misalign
);

  localparam int HALF_W = 2 * BYTE_W;

  logic [DATA_W-1:0] wrDataNext;
  logic [DATA_W-1:0] loadNext;
  logic [BYTE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [OFF_W-1:0]  halfOff;
  int                byteIdx;
  int                halfIdx;

  // store lane steering: the source is replicated so any lane can be enabled
  for (genvar g = 0; g < LANES; g++) begin : gStoreLane
    logic [BYTE_W-1:0] laneByte;
    always_comb begin
      case (strobe.size)
        SZ_BYTE: laneByte = storeData[BYTE_W-1:0];
        SZ_HALF: laneByte = (g % 2 == 1) ? storeData[HALF_W-1:BYTE_W] : storeData[BYTE_W-1:0];
        default: laneByte = storeData[g*BYTE_W +: BYTE_W];
      endcase
    end
    assign wrDataNext[g*BYTE_W +: BYTE_W] = laneByte;
  end

  // load extraction and extension
  always_comb begin
    halfOff  = {addrLow[OFF_W-1:1], 1'b0};
    byteIdx  = LANES - 1 - int'(addrLow);
    halfIdx  = LANES - 2 - int'(halfOff);
    pickByte = memReadWord[byteIdx*BYTE_W +: BYTE_W];
    pickHalf = memReadWord[halfIdx*BYTE_W +: HALF_W];
    case (strobe.size)
      SZ_BYTE: loadNext = strobe.signExt ? {{(DATA_W-BYTE_W){pickByte[BYTE_W-1]}}, pickByte}
                                         : {{(DATA_W-BYTE_W){1'b0}}, pickByte};
      SZ_HALF: loadNext = strobe.signExt ? {{(DATA_W-HALF_W){pickHalf[HALF_W-1]}}, pickHalf}
                                         : {{(DATA_W-HALF_W){1'b0}}, pickHalf};
      SZ_WORD: loadNext = memReadWord;
      default: loadNext = '0;
    endcase
    if (strobe.misalign) loadNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid   <= 1'b0;
      wrEnable   <= '0;
      misalign   <= 1'b0;
      wrData     <= '0;
      loadResult <= '0;
    end else begin
      rspValid <= strobe.capture;
      misalign <= strobe.capture & strobe.misalign;
      wrEnable <= strobe.capture ? laneMask : '0;
      if (strobe.capture) begin
        wrData     <= wrDataNext;
        loadResult <= loadNext;
      end
    end
  end

endmodule

// File: rtl/memAligner.sv
module memAligner
  import memAlignPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqIsStore,
  input  logic [1:0]        reqSize,
  input  logic              reqUnsigned,
  input  logic [OFF_W-1:0]  reqAddrLow,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memReadWord,
  output logic              rspValid,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  wrEnable,
  output logic [DATA_W-1:0] loadResult,
  output logic              misalign
);

  alignStrobe_t     strobe;
  logic [LANES-1:0] laneMask;

  memAlignCtrl #(.LANES(LANES), .OFF_W(OFF_W)) u_ctrl (
    .reqValid   (reqValid),
    .reqIsStore (reqIsStore),
    .reqSize    (reqSize),
    .reqUnsigned(reqUnsigned),
    .addrLow    (reqAddrLow),
    .strobe     (strobe),
    .laneMask   (laneMask)
  );

  memAlignData #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANES(LANES), .OFF_W(OFF_W)) u_data (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .laneMask   (laneMask),
    .addrLow    (reqAddrLow),
    .storeData  (storeData),
    .memReadWord(memReadWord),
    .rspValid   (rspValid),
    .wrData     (wrData),
    .wrEnable   (wrEnable),
    .loadResult (loadResult),
    .misalign   (misalign)
  );

endmodule

// File: rtl/memAlignerChecker.sv
module memAlignerChecker (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic        reqIsStore,
  input logic [1:0]  reqSize,
  input logic        reqUnsigned,
  input logic        rspValid,
  input logic [3:0]  wrEnable,
  input logic [31:0] loadResult,
  input logic        misalign
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!rspValid && wrEnable == 4'b0000 && !misalign));

  a_r5_misalign_blocks_write: assert property (@(posedge clk) disable iff (rst)
    misalign |-> wrEnable == 4'b0000);

  a_r6_load_no_write: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqIsStore) |=> wrEnable == 4'b0000);

  a_r2_byte_store_one_lane: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqIsStore && reqSize == 2'b00) |=> $countones(wrEnable) == 1);

  a_r7_unsigned_byte_zero_top: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqIsStore && reqUnsigned && reqSize == 2'b00) |=> loadResult[31:8] == 24'd0);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!rspValid && wrEnable == 4'b0000 && !misalign));

endmodule

bind memAligner memAlignerChecker u_checker (
  .clk        (clk),
  .rst        (rst),
  .reqValid   (reqValid),
  .reqIsStore (reqIsStore),
  .reqSize    (reqSize),
  .reqUnsigned(reqUnsigned),
  .rspValid   (rspValid),
  .wrEnable   (wrEnable),
  .loadResult (loadResult),
  .misalign   (misalign)
);

// File: tb/memAligner_bench.sv
module memAligner_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqIsStore = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic        reqUnsigned = 1'b0;
  logic [1:0]  reqAddrLow = 2'b00;
  logic [31:0] storeData = '0;
  logic [31:0] memReadWord = '0;
  logic        rspValid;
  logic [31:0] wrData;
  logic [3:0]  wrEnable;
  logic [31:0] loadResult;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memAligner u_memAligner (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .reqAddrLow(reqAddrLow),
    .storeData(storeData), .memReadWord(memReadWord), .rspValid(rspValid),
    .wrData(wrData), .wrEnable(wrEnable), .loadResult(loadResult), .misalign(misalign)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one request per clock; behavioural byte model computes the response
  task automatic step(bit v, bit st, bit [1:0] sz, bit un, bit [1:0] off,
                      bit [31:0] sd, bit [31:0] mw);
    int        span;
    bit        bad;
    bit [3:0]  expEn;
    bit [31:0] expData, expLoad, extMask;
    string     tag;
    @(negedge clk);
    reqValid = v; reqIsStore = st; reqSize = sz; reqUnsigned = un;
    reqAddrLow = off; storeData = sd; memReadWord = mw;
    span = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
    bad  = (sz == 2'b11) || (sz == 2'b01 && off[0]) || (sz == 2'b10 && off != 2'b00);
    expEn = '0; expLoad = '0;
    expData = (sz == 2'b00) ? {4{sd[7:0]}} : (sz == 2'b01) ? {2{sd[15:0]}} : sd;
    if (!bad) begin
      for (int j = 0; j < span; j++) begin
        if (st) expEn[3 - (int'(off) + j)] = 1'b1;
        expLoad = (expLoad << 8) | 32'(mw[(3 - (int'(off) + j))*8 +: 8]);
      end
      if (!un && span < 4 && expLoad[span*8-1]) begin
        extMask = 32'hFFFF_FFFF << (span*8);
        expLoad = expLoad | extMask;
      end
    end
    if (!v) tag = "R10";
    else if (bad) tag = "R5";
    else if (st) tag = (span == 1) ? "R2" : (span == 2) ? "R3" : "R4";
    else tag = (span == 1) ? "R7" : (span == 2) ? "R8" : "R9";
    @(posedge clk);
    #1;
    chk("R10", "rspValid", 32'(rspValid), 32'(v));
    if (!v) begin
      chk(tag, "wrEnable", 32'(wrEnable), 32'd0);
      chk(tag, "misalign", 32'(misalign), 32'd0);
    end else begin
      chk(tag, "misalign", 32'(misalign), 32'(bad));
      chk(st ? tag : "R6", "wrEnable", 32'(wrEnable), 32'(expEn));
      if (st && !bad) chk(tag, "wrData", wrData, expData);
      if (!st) chk(tag, "loadResult", loadResult, expLoad);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a pending request
    reqValid = 1'b1; reqIsStore = 1'b1; reqSize = 2'b10;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rspValid", 32'(rspValid), 32'd0);
    chk("R1", "wrEnable", 32'(wrEnable), 32'd0);
    chk("R1", "misalign", 32'(misalign), 32'd0);
    @(negedge clk);
    rst = 1'b0; reqValid = 1'b0;

    // R2: byte stores at every offset
    for (int k = 0; k < 4; k++) step(1, 1, 2'b00, 0, 2'(k), 32'h1234_56A5, 32'h0);
    // R3, R4: halfword and word stores
    step(1, 1, 2'b01, 0, 2'd0, 32'hDEAD_BEEF, 32'h0);
    step(1, 1, 2'b01, 0, 2'd2, 32'h0102_8304, 32'h0);
    step(1, 1, 2'b10, 0, 2'd0, 32'hCAFE_F00D, 32'h0);
    // R5: misaligned stores and loads, reserved size
    step(1, 1, 2'b01, 0, 2'd1, 32'hFFFF_FFFF, 32'h0);
    step(1, 1, 2'b01, 0, 2'd3, 32'hFFFF_FFFF, 32'h0);
    step(1, 1, 2'b10, 0, 2'd2, 32'hFFFF_FFFF, 32'h0);
    step(1, 0, 2'b10, 0, 2'd3, 32'h0, 32'h89AB_CDEF);
    step(1, 1, 2'b11, 0, 2'd0, 32'hFFFF_FFFF, 32'h0);
    step(1, 0, 2'b01, 1, 2'd1, 32'h0, 32'h89AB_CDEF);
    // R7: byte loads, signed and unsigned, every offset
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 2'b00, 0, 2'(k), 32'h0, 32'h80F1_7F22);
      step(1, 0, 2'b00, 1, 2'(k), 32'h0, 32'h80F1_7F22);
    end
    // R8: halfword loads
    step(1, 0, 2'b01, 0, 2'd0, 32'h0, 32'h8001_7FFE);
    step(1, 0, 2'b01, 1, 2'd0, 32'h0, 32'h8001_7FFE);
    step(1, 0, 2'b01, 0, 2'd2, 32'h0, 32'h1234_F00F);
    step(1, 1, 2'b01, 1, 2'd2, 32'h0, 32'h1234_F00F);
    step(1, 0, 2'b01, 1, 2'd2, 32'h0, 32'h1234_F00F);
    // R9: word load
    step(1, 0, 2'b10, 0, 2'd0, 32'h0, 32'h89AB_CDEF);
    // R10: idle cycles between requests
    step(0, 1, 2'b10, 0, 2'd0, 32'hFFFF_FFFF, 32'h0);
    step(1, 1, 2'b00, 0, 2'd0, 32'h0000_0077, 32'h0);
    step(0, 0, 2'b00, 0, 2'd0, 32'h0, 32'h0);
    // mixed stream, back to back and idle
    for (int i = 0; i < 2000; i++)
      step(($urandom % 5) != 0, 1'($urandom), 2'($urandom), 1'($urandom),
           2'($urandom), $urandom, $urandom);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule